// File: doc/BRIEF.md
# Multi-Cycle Load/Store Integer Core

A compact 32-bit processor that runs each instruction as a short sequence of states: FETCH, DECODE, EXECUTE, an optional MEM step, and an optional WRITEBACK step. It has no shared buses. Values move through dedicated holding registers:

- the instruction register;
- operand latches A and B;
- the result latch C;
- a memory address latch and a store data latch.

The 32-entry general register file has two ports. In any cycle it serves either two reads or one write, never both. Reads happen only in DECODE and the single write only in WRITEBACK.

The core shares one synchronous memory port between fetches and data accesses. The port is word-indexed: each address names one 32-bit word. Read data appears one cycle after the address is presented. The program counter also counts in words. The integer set covers:

- register and immediate arithmetic and logic;
- shifts by one position;
- signed compare-and-set;
- word load and store;
- branches on zero;
- register jump and jump-and-link;
- a no-op that returns to fetch;
- halt, which parks the core until reset.

Top module: `mc_core`

## Requirements
- R1: While `rst` (synchronous, active high) is asserted, and in the first cycle after it is released, `halted` is 0 and `memWe` is 0. The first cycle after release fetches from word address 0.
- R2: The register file is read only in DECODE and written only in WRITEBACK, never both in one cycle.
- R3: Register 0 always reads as zero. A result aimed at it is discarded.
- R4: I-type fields are opcode[31:26], rs1[25:21], rd[20:16], imm[15:0]. R-type fields are opcode[31:26]=0x00, rs1[25:21], rs2[20:16], rd[15:11], unused[10:6], func[5:0]. A store takes its data register from bits [20:16].
- R5: R-type function codes are 0x20 add, 0x22 sub, 0x24 and, 0x25 or, 0x26 xor, 0x00 shift rs1 left by one, and 0x02 shift rs1 right by one with zero fill.
- R6: The immediate ops combine rs1 with sext(imm): 0x08 add, 0x0A sub, 0x0C and, 0x0D or, 0x0E xor.
- R7: The compare-and-set ops write 1 when the signed test of rs1 against sext(imm) holds and 0 otherwise. The codes are 0x19 greater, 0x1A equal, 0x1B greater-or-equal, 0x1C less, 0x1D not-equal, 0x1E less-or-equal.
- R8: Load word (0x23) writes rd from memory at sext(imm)+rs1. Store word (0x2B) writes rd to memory at that address.
- R9: Branch-if-zero (0x04) and branch-if-nonzero (0x05) test rs1. A taken branch goes to PC+1+sext(imm); otherwise the PC becomes PC+1.
- R10: Register jump (0x12) sets PC to rs1. Jump-and-link (0x13) writes PC+1 into register 31 and sets PC to rs1. Neither writes any other register.
- R11: Halt (0x3F) enters a terminal state. `halted` stays 1 and no memory write happens until reset, which clears it.
- R12: The no-op (0x3E), any other opcode, and an unknown R-type function advance PC by one and return to FETCH. They change no register and no memory.
- R13: Cycle counts are: ALU op 4, load 5, store 4, branch or register jump 3, jump-and-link 4. A store drives `memWe` in its 4th cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| memAddr | output | 32 | Word address: PC during fetch, data address during MEM |
| memWe | output | 1 | Store strobe for the word at `memAddr` |
| memWrData | output | 32 | Store data |
| memRdData | input | 32 | Word read from the previous cycle's `memAddr` |
| halted | output | 1 | High once halt has executed, until reset |

## Verification
The core runs one program that mixes every instruction class. Each result is stored to its own data word, so every opcode and function code is read back through memory.

Operands pair a positive with a negative value. This separates signed from unsigned compares, arithmetic from logical right shift, and sign-extended immediates from zero-extended ones. Skipped instructions sit in the shadow of taken branches and jumps, and they write a register that is later stored. A wrong target or a missed skip therefore shows up as a changed word.

A backward loop proves that negative offsets work and that the iteration count is right. Timing of the first store and stickiness of the halt are checked at the port.

// File: rtl/mc_core_pkg.sv
package mc_core_pkg;

  localparam int INSTR_W = 32;
  localparam int REG_AW  = 5;

  // primary opcodes
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_BEQZ  = 6'h04;
  localparam logic [5:0] OP_BNEZ  = 6'h05;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_SUBI  = 6'h0A;
  localparam logic [5:0] OP_ANDI  = 6'h0C;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_XORI  = 6'h0E;
  localparam logic [5:0] OP_JR    = 6'h12;
  localparam logic [5:0] OP_JALR  = 6'h13;
  localparam logic [5:0] OP_SGTI  = 6'h19;
  localparam logic [5:0] OP_SEQI  = 6'h1A;
  localparam logic [5:0] OP_SGEI  = 6'h1B;
  localparam logic [5:0] OP_SLTI  = 6'h1C;
  localparam logic [5:0] OP_SNEI  = 6'h1D;
  localparam logic [5:0] OP_SLEI  = 6'h1E;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_SNOP  = 6'h3E;
  localparam logic [5:0] OP_HALT  = 6'h3F;

  // R-type function codes
  localparam logic [5:0] FN_SLL1 = 6'h00;
  localparam logic [5:0] FN_SRL1 = 6'h02;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;

  localparam logic [REG_AW-1:0] LINK_REG = 5'd31;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB, ST_HALT
  } state_e;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLL1, ALU_SRL1,
    ALU_LT, ALU_GT, ALU_LE, ALU_GE, ALU_EQ, ALU_NE
  } alu_op_e;

  typedef enum logic [3:0] {
    CL_ALU_R, CL_ALU_I, CL_LOAD, CL_STORE, CL_BEQZ, CL_BNEZ,
    CL_JR, CL_JALR, CL_HALT, CL_NOP
  } instr_class_e;

  typedef enum logic [1:0] { PC_INC, PC_BRANCH, PC_REG } pc_sel_e;

  typedef enum logic [1:0] { DST_RTYPE, DST_ITYPE, DST_LINK } dst_sel_e;

  typedef struct packed {
    logic     irLoad;
    logic     rfRead;
    logic     useImm;
    alu_op_e  aluOp;
    logic     cLoad;
    logic     cFromLink;
    logic     marLoad;
    logic     mdrLoad;
    logic     pcLoad;
    pc_sel_e  pcSel;
    logic     rfWrite;
    logic     wbFromMem;
    dst_sel_e dstSel;
    logic     memWrite;
    logic     addrFromMar;
  } ctrl_t;

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rdEn,
  input  logic [AW-1:0]   rdAddrA,
  input  logic [AW-1:0]   rdAddrB,
  output logic [XLEN-1:0] rdDataA,
  output logic [XLEN-1:0] rdDataB,
  input  logic            wrEn,
  input  logic [AW-1:0]   wrAddr,
  input  logic [XLEN-1:0] wrData
);

  logic [XLEN-1:0] regs [NREG];

  assign rdDataA = regs[rdAddrA];
  assign rdDataB = regs[rdAddrB];

  // entry 0 is cleared by reset and never written afterwards
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      for (int i = 1; i < NREG; i++) begin
        if (wrEn && wrAddr == AW'(i)) regs[i] <= wrData;
      end
    end
  end

  // R2: port budget is two reads or one write per cycle
  assert_port_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(rdEn && wrEn));

  // R3: the zero register keeps its value
  assert_zero_reg_R3: assert property (@(posedge clk) disable iff (rst)
    regs[0] == '0);

endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_core_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] lhs,
  input  logic [XLEN-1:0] rhs,
  output logic [XLEN-1:0] res
);

  logic flag;

  always_comb begin
    flag = 1'b0;
    res  = '0;
    case (op)
      ALU_ADD:  res = lhs + rhs;
      ALU_SUB:  res = lhs - rhs;
      ALU_AND:  res = lhs & rhs;
      ALU_OR:   res = lhs | rhs;
      ALU_XOR:  res = lhs ^ rhs;
      ALU_SLL1: res = lhs << 1;
      ALU_SRL1: res = lhs >> 1;
      default: begin
        case (op)
          ALU_LT:  flag = $signed(lhs) <  $signed(rhs);
          ALU_GT:  flag = $signed(lhs) >  $signed(rhs);
          ALU_LE:  flag = $signed(lhs) <= $signed(rhs);
          ALU_GE:  flag = $signed(lhs) >= $signed(rhs);
          ALU_EQ:  flag = lhs == rhs;
          ALU_NE:  flag = lhs != rhs;
          default: flag = 1'b0;
        endcase
        res = {{(XLEN-1){1'b0}}, flag};
      end
    endcase
  end

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_core_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  input  logic [XLEN-1:0]  memRdData,
  output logic [XLEN-1:0]  memAddr,
  output logic [XLEN-1:0]  memWrData,
  output logic [5:0]       irOpcode,
  output logic [5:0]       irFunc,
  output logic             aIsZero
);

  localparam int IMM_W = 16;

  logic [XLEN-1:0] pc, regA, regB, regC, mar, mdr;
  logic [5:0]      irOp;
  logic [20:0]     irLow;    // rd/rs2, rd(R), unused, func / immediate
  logic [XLEN-1:0] immExt, aluRhs, aluRes, rdA, rdB, wbData;
  logic [REG_AW-1:0] wbAddr;

  assign immExt = {{(XLEN-IMM_W){irLow[IMM_W-1]}}, irLow[IMM_W-1:0]};
  assign aluRhs = ctrl.useImm ? immExt : regB;

  mc_alu #(.XLEN(XLEN)) u_alu (
    .op (ctrl.aluOp),
    .lhs(regA),
    .rhs(aluRhs),
    .res(aluRes)
  );

  always_comb begin
    case (ctrl.dstSel)
      DST_RTYPE: wbAddr = irLow[15:11];
      DST_LINK:  wbAddr = LINK_REG;
      default:   wbAddr = irLow[20:16];
    endcase
  end

  assign wbData = ctrl.wbFromMem ? memRdData : regC;

  // read addresses come straight from the fetched word while it arrives
  mc_regfile #(.XLEN(XLEN), .NREG(32)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .rdEn   (ctrl.rfRead),
    .rdAddrA(memRdData[25:21]),
    .rdAddrB(memRdData[20:16]),
    .rdDataA(rdA),
    .rdDataB(rdB),
    .wrEn   (ctrl.rfWrite),
    .wrAddr (wbAddr),
    .wrData (wbData)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      irOp  <= '0;
      irLow <= '0;
      regA  <= '0;
      regB  <= '0;
      regC  <= '0;
      mar   <= '0;
      mdr   <= '0;
    end else begin
      if (ctrl.irLoad) begin
        irOp  <= memRdData[31:26];
        irLow <= memRdData[20:0];
      end
      if (ctrl.rfRead) begin
        regA <= rdA;
        regB <= rdB;
      end
      if (ctrl.cLoad)   regC <= ctrl.cFromLink ? pc + XLEN'(1) : aluRes;
      if (ctrl.marLoad) mar  <= aluRes;
      if (ctrl.mdrLoad) mdr  <= regB;
      if (ctrl.pcLoad) begin
        case (ctrl.pcSel)
          PC_BRANCH: pc <= pc + XLEN'(1) + immExt;
          PC_REG:    pc <= regA;
          default:   pc <= pc + XLEN'(1);
        endcase
      end
    end
  end

  assign memAddr   = ctrl.addrFromMar ? mar : pc;
  assign memWrData = mdr;
  assign irOpcode  = irOp;
  assign irFunc    = irLow[5:0];
  assign aIsZero   = (regA == '0);

  // R12: a sequential step moves the PC by exactly one word
  assert_pc_step_R12: assert property (@(posedge clk) disable iff (rst)
    (ctrl.pcLoad && ctrl.pcSel == PC_INC) |=> pc == $past(pc) + XLEN'(1));

endmodule

// File: rtl/mc_control.sv
module mc_control
  import mc_core_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] irOpcode,
  input  logic [5:0] irFunc,
  input  logic       aIsZero,
  output ctrl_t      ctrl,
  output logic       halted
);

  state_e       state, nextState;
  instr_class_e cls;
  alu_op_e      decOp;

  always_comb begin
    cls   = CL_NOP;
    decOp = ALU_ADD;
    case (irOpcode)
      OP_RTYPE: begin
        cls = CL_ALU_R;
        case (irFunc)
          FN_ADD:  decOp = ALU_ADD;
          FN_SUB:  decOp = ALU_SUB;
          FN_AND:  decOp = ALU_AND;
          FN_OR:   decOp = ALU_OR;
          FN_XOR:  decOp = ALU_XOR;
          FN_SLL1: decOp = ALU_SLL1;
          FN_SRL1: decOp = ALU_SRL1;
          default: cls   = CL_NOP;
        endcase
      end
      OP_ADDI: begin cls = CL_ALU_I; decOp = ALU_ADD; end
      OP_SUBI: begin cls = CL_ALU_I; decOp = ALU_SUB; end
      OP_ANDI: begin cls = CL_ALU_I; decOp = ALU_AND; end
      OP_ORI:  begin cls = CL_ALU_I; decOp = ALU_OR;  end
      OP_XORI: begin cls = CL_ALU_I; decOp = ALU_XOR; end
      OP_SGTI: begin cls = CL_ALU_I; decOp = ALU_GT;  end
      OP_SEQI: begin cls = CL_ALU_I; decOp = ALU_EQ;  end
      OP_SGEI: begin cls = CL_ALU_I; decOp = ALU_GE;  end
      OP_SLTI: begin cls = CL_ALU_I; decOp = ALU_LT;  end
      OP_SNEI: begin cls = CL_ALU_I; decOp = ALU_NE;  end
      OP_SLEI: begin cls = CL_ALU_I; decOp = ALU_LE;  end
      OP_LW:   cls = CL_LOAD;
      OP_SW:   cls = CL_STORE;
      OP_BEQZ: cls = CL_BEQZ;
      OP_BNEZ: cls = CL_BNEZ;
      OP_JR:   cls = CL_JR;
      OP_JALR: cls = CL_JALR;
      OP_HALT: cls = CL_HALT;
      default: cls = CL_NOP;
    endcase
  end

  always_comb begin
    ctrl        = '0;
    ctrl.aluOp  = decOp;
    ctrl.useImm = (cls != CL_ALU_R);
    case (cls)
      CL_ALU_R: ctrl.dstSel = DST_RTYPE;
      CL_JALR:  ctrl.dstSel = DST_LINK;
      default:  ctrl.dstSel = DST_ITYPE;
    endcase
    nextState = state;
    case (state)
      ST_FETCH: nextState = ST_DECODE;
      ST_DECODE: begin
        ctrl.irLoad = 1'b1;
        ctrl.rfRead = 1'b1;
        nextState   = ST_EXEC;
      end
      ST_EXEC: begin
        ctrl.pcLoad = 1'b1;
        ctrl.pcSel  = PC_INC;
        nextState   = ST_FETCH;
        case (cls)
          CL_ALU_R, CL_ALU_I: begin
            ctrl.cLoad = 1'b1;
            nextState  = ST_WB;
          end
          CL_LOAD: begin
            ctrl.aluOp   = ALU_ADD;
            ctrl.marLoad = 1'b1;
            nextState    = ST_MEM;
          end
          CL_STORE: begin
            ctrl.aluOp   = ALU_ADD;
            ctrl.marLoad = 1'b1;
            ctrl.mdrLoad = 1'b1;
            nextState    = ST_MEM;
          end
          CL_BEQZ: ctrl.pcSel = aIsZero  ? PC_BRANCH : PC_INC;
          CL_BNEZ: ctrl.pcSel = !aIsZero ? PC_BRANCH : PC_INC;
          CL_JR:   ctrl.pcSel = PC_REG;
          CL_JALR: begin
            ctrl.pcSel     = PC_REG;
            ctrl.cLoad     = 1'b1;
            ctrl.cFromLink = 1'b1;
            nextState      = ST_WB;
          end
          CL_HALT: begin
            ctrl.pcLoad = 1'b0;
            nextState   = ST_HALT;
          end
          default: nextState = ST_FETCH;
        endcase
      end
      ST_MEM: begin
        ctrl.addrFromMar = 1'b1;
        if (cls == CL_STORE) begin
          ctrl.memWrite = 1'b1;
          nextState     = ST_FETCH;
        end else begin
          nextState = ST_WB;
        end
      end
      ST_WB: begin
        ctrl.rfWrite   = 1'b1;
        ctrl.wbFromMem = (cls == CL_LOAD);
        nextState      = ST_FETCH;
      end
      default: nextState = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= nextState;
  end

  assign halted = (state == ST_HALT);

  // R11: once parked, only reset leaves the halt state
  assert_halted_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R11: no store strobe while parked
  assert_no_store_halted_R11: assert property (@(posedge clk) disable iff (rst)
    halted |-> !ctrl.memWrite);

  // R13: writeback only follows execute or a memory step
  assert_wb_predecessor_R13: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WB) |-> ($past(state) == ST_EXEC || $past(state) == ST_MEM));

endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_core_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] memAddr,
  output logic            memWe,
  output logic [XLEN-1:0] memWrData,
  input  logic [XLEN-1:0] memRdData,
  output logic            halted
);

  ctrl_t      ctrl;
  logic [5:0] irOpcode, irFunc;
  logic       aIsZero;

  mc_control u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .irOpcode(irOpcode),
    .irFunc  (irFunc),
    .aIsZero (aIsZero),
    .ctrl    (ctrl),
    .halted  (halted)
  );

  mc_datapath #(.XLEN(XLEN)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .memRdData(memRdData),
    .memAddr  (memAddr),
    .memWrData(memWrData),
    .irOpcode (irOpcode),
    .irFunc   (irFunc),
    .aIsZero  (aIsZero)
  );

  assign memWe = ctrl.memWrite;

endmodule

// File: tb/mc_core_test.sv
module mc_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] memAddr, memWrData, memRdData;
  logic        memWe, halted;

  always #5 clk = ~clk;

  mc_core uut (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memWe(memWe),
    .memWrData(memWrData), .memRdData(memRdData), .halted(halted)
  );

  logic [31:0] mem [256];
  always @(posedge clk) begin
    if (memWe) mem[memAddr[7:0]] <= memWrData;
    memRdData <= mem[memAddr[7:0]];
  end

  // encodings from R4..R12
  localparam logic [5:0] BEQZ=6'h04, BNEZ=6'h05, ADDI=6'h08, SUBI=6'h0A, ANDI=6'h0C,
    ORI=6'h0D, XORI=6'h0E, JR=6'h12, JALR=6'h13, SGTI=6'h19, SEQI=6'h1A, SGEI=6'h1B,
    SLTI=6'h1C, SNEI=6'h1D, SLEI=6'h1E, LW=6'h23, SW=6'h2B, SNOP=6'h3E, HALT=6'h3F;

  function automatic logic [31:0] encI(logic [5:0] op, int rs1, int rd, int imm);
    logic [31:0] r;
    r = {op, rs1[4:0], rd[4:0], imm[15:0]};
    return r;
  endfunction

  function automatic logic [31:0] encR(int rs1, int rs2, int rd, logic [5:0] fn);
    logic [31:0] r;
    r = {6'h00, rs1[4:0], rs2[4:0], rd[4:0], 5'd0, fn};
    return r;
  endfunction

  // {data word address, requirement number, expected word}
  localparam int NV = 26;
  localparam logic [43:0] VEC [NV] = '{
    {8'd128, 4'd4,  32'h0000_0002},  // R4 add with rd in [15:11]
    {8'd129, 4'd5,  32'h0000_0008},  // R5 sub
    {8'd130, 4'd5,  32'h0000_0005},  // R5 and
    {8'd131, 4'd5,  32'hFFFF_FFFD},  // R5 or
    {8'd132, 4'd5,  32'hFFFF_FFF8},  // R5 xor
    {8'd133, 4'd5,  32'hFFFF_FFFA},  // R5 shift left
    {8'd134, 4'd5,  32'h7FFF_FFFE},  // R5 logical shift right
    {8'd135, 4'd7,  32'h0000_0001},  // R7 less, signed
    {8'd136, 4'd7,  32'h0000_0001},  // R7 greater
    {8'd137, 4'd7,  32'h0000_0001},  // R7 equal
    {8'd138, 4'd7,  32'h0000_0000},  // R7 greater-or-equal false
    {8'd139, 4'd7,  32'h0000_0000},  // R7 not-equal false
    {8'd140, 4'd7,  32'h0000_0001},  // R7 less-or-equal at equality
    {8'd141, 4'd3,  32'h0000_0000},  // R3 write to register 0 lost
    {8'd142, 4'd8,  32'h0000_000C},  // R8 load then add
    {8'd143, 4'd9,  32'h0000_0001},  // R9 not-taken and taken branch
    {8'd144, 4'd10, 32'h0000_0028},  // R10 link value 40
    {8'd145, 4'd12, 32'h0000_0000},  // R12 unknown op and no-op write nothing
    {8'd146, 4'd6,  32'hFFFF_FFFE},  // R6 sub immediate
    {8'd147, 4'd6,  32'h0000_000D},  // R6 and immediate
    {8'd148, 4'd6,  32'hFFFF_FFF0},  // R6 or immediate, sign extended
    {8'd149, 4'd6,  32'hFFFF_FFFA},  // R6 xor immediate
    {8'd150, 4'd9,  32'h0000_0003},  // R9 backward loop count
    {8'd151, 4'd9,  32'h0000_0000},  // R9 taken branch skips
    {8'd152, 4'd11, 32'hA5A5_A5A5},  // R11 nothing after halt
    {8'd153, 4'd10, 32'h0000_0000}   // R10 jump shadow skipped
  };

  int checks = 0, fails = 0;
  int cyc = 0;
  int firstWr = -1;
  int haltWrites = 0;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (!rst && memWe && firstWr < 0) firstWr = cyc;
    if (!rst && halted && memWe) haltWrites++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadProgram();
    logic [31:0] p [68];
    for (int i = 0; i < 256; i++) mem[i] <= 32'h0;
    p[0]  = encI(ADDI, 0, 1, 5);
    p[1]  = encI(ADDI, 0, 2, -3);
    p[2]  = encR(1, 2, 3, 6'h20);
    p[3]  = encI(SW, 0, 3, 128);
    p[4]  = encR(1, 2, 4, 6'h22);
    p[5]  = encI(SW, 0, 4, 129);
    p[6]  = encR(1, 2, 5, 6'h24);
    p[7]  = encI(SW, 0, 5, 130);
    p[8]  = encR(1, 2, 6, 6'h25);
    p[9]  = encI(SW, 0, 6, 131);
    p[10] = encR(1, 2, 7, 6'h26);
    p[11] = encI(SW, 0, 7, 132);
    p[12] = encR(2, 0, 8, 6'h00);
    p[13] = encI(SW, 0, 8, 133);
    p[14] = encR(2, 0, 9, 6'h02);
    p[15] = encI(SW, 0, 9, 134);
    p[16] = encI(SLTI, 2, 10, 0);
    p[17] = encI(SW, 0, 10, 135);
    p[18] = encI(SGTI, 2, 11, -5);
    p[19] = encI(SW, 0, 11, 136);
    p[20] = encI(SEQI, 1, 12, 5);
    p[21] = encI(SW, 0, 12, 137);
    p[22] = encI(SGEI, 1, 13, 6);
    p[23] = encI(SW, 0, 13, 138);
    p[24] = encI(SNEI, 1, 14, 5);
    p[25] = encI(SW, 0, 14, 139);
    p[26] = encI(SLEI, 2, 15, -3);
    p[27] = encI(SW, 0, 15, 140);
    p[28] = encI(ADDI, 0, 0, 7);
    p[29] = encI(SW, 0, 0, 141);
    p[30] = encI(LW, 0, 16, 128);
    p[31] = encI(ADDI, 16, 16, 10);
    p[32] = encI(SW, 0, 16, 142);
    p[33] = encI(BEQZ, 1, 0, 5);
    p[34] = encI(ADDI, 0, 17, 1);
    p[35] = encI(BNEZ, 1, 0, 1);
    p[36] = encI(ADDI, 0, 17, 99);
    p[37] = encI(SW, 0, 17, 143);
    p[38] = encI(ADDI, 0, 18, 42);
    p[39] = encI(JALR, 18, 0, 0);
    p[40] = encI(ADDI, 0, 19, 99);
    p[41] = encI(ADDI, 0, 19, 98);
    p[42] = encI(SW, 0, 31, 144);
    p[43] = encI(ADDI, 0, 20, 46);
    p[44] = encI(JR, 20, 0, 0);
    p[45] = encI(ADDI, 0, 21, 7);
    p[46] = encI(6'h3D, 1, 21, 5);
    p[47] = encI(SNOP, 1, 21, 5);
    p[48] = encI(SW, 0, 21, 145);
    p[49] = encI(SUBI, 1, 22, 7);
    p[50] = encI(SW, 0, 22, 146);
    p[51] = encI(ANDI, 2, 23, 15);
    p[52] = encI(SW, 0, 23, 147);
    p[53] = encI(ORI, 0, 24, -16);
    p[54] = encI(SW, 0, 24, 148);
    p[55] = encI(XORI, 1, 25, -1);
    p[56] = encI(SW, 0, 25, 149);
    p[57] = encI(ADDI, 0, 26, 3);
    p[58] = encI(ADDI, 27, 27, 1);
    p[59] = encI(ADDI, 26, 26, -1);
    p[60] = encI(BNEZ, 26, 0, -3);
    p[61] = encI(SW, 0, 27, 150);
    p[62] = encI(BEQZ, 0, 0, 1);
    p[63] = encI(ADDI, 0, 28, 1);
    p[64] = encI(SW, 0, 28, 151);
    p[65] = encI(SW, 0, 19, 153);
    p[66] = encI(HALT, 0, 0, 0);
    p[67] = encI(SW, 0, 1, 152);
    for (int i = 0; i < 68; i++) mem[i] <= p[i];
    mem[152] <= 32'hA5A5_A5A5;
  endtask

  initial begin
    bit done;
    loadProgram();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: quiet while reset is held
    check("R1 halted in reset", {31'd0, halted}, 32'd0);
    check("R1 memWe in reset", {31'd0, memWe}, 32'd0);
    rst = 1'b0;
    check("R1 first fetch address", memAddr, 32'd0);

    done = 1'b0;
    for (int w = 0; w < 5000 && !done; w++) begin
      @(negedge clk);
      if (halted) done = 1'b1;
    end
    checks++;
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog: halted actual=0 expected=1");
    end

    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      v = VEC[i];
      checks++;
      if (mem[v[43:36]] !== v[31:0]) begin
        fails++;
        $display("FAIL R%0d word %0d actual=%h expected=%h",
                 v[35:32], v[43:36], mem[v[43:36]], v[31:0]);
      end
    end

    // R13: first store (instruction 3 after three ALU ops) strobes at cycle 15
    check("R13 first store cycle", firstWr, 32'd15);

    // R11: halt is sticky with no writes
    repeat (30) @(negedge clk);
    check("R11 halted holds", {31'd0, halted}, 32'd1);
    check("R11 no writes after halt", haltWrites, 32'd0);

    // R11/R1: reset clears halted and restarts at word 0
    rst = 1'b1;
    @(negedge clk);
    check("R11 reset clears halted", {31'd0, halted}, 32'd0);
    rst = 1'b0;
    check("R1 restart fetch address", memAddr, 32'd0);
    check("R1 no write after restart", {31'd0, memWe}, 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule